// File: doc/BRIEF.md
# Compare-to-Predicate Unit

This block keeps a small file of one-bit condition registers and executes the compare instructions that write them. Each cycle it looks at the instruction word. If the word is a register-register or register-immediate compare, it evaluates one of twelve conditions on operand A against operand B or a sign-extended 13-bit immediate. It then writes the boolean outcome into the condition register that the instruction names. A read port lets the surrounding core look up any condition register, so the core can decide whether a later instruction executes.

The unit does not read general registers. The core supplies operand values A and B, already fetched using the source fields of the instruction. The core also supplies `issue_en_i`, which is the already-resolved outcome of the compare's own guard. Entry 0 of the file is hardwired true. The asynchronous active-low reset is released synchronously inside the block through a short synchronizer. A write lands on the clock edge and shows on the read port from then on, so the next instruction already sees it.

Top module: `pred_cmp_unit`

## Requirements
- R1: The file holds 16 condition entries; after reset, entries 1 to 15 read false.
- R2: Entry 0 always reads true; a compare naming entry 0 as target changes nothing.
- R3: Register form: instr[27:23]=5'b00010 and instr[7:4]=4'b1111; condition code in instr[3:0], target entry in instr[21:18], instr[22] ignored, compared against `opb_i`.
- R4: Immediate form: instr[27:26]=2'b11; condition code in instr[25:22], target in instr[21:18], immediate in instr[12:0] sign-extended to 32 bits and used in place of `opb_i` (which is then ignored).
- R5: Code 0 writes A==B; code 1 writes A!=B.
- R6: Codes 2, 3, 4, 5 write signed A<B, A>=B, A<=B, A>B.
- R7: Codes 6, 7, 8, 9 write unsigned A<B, A>=B, A<=B, A>B.
- R8: Code 10 writes the carry out of bit 31 of the 32-bit sum A+B (A+immediate in the immediate form).
- R9: Code 11 writes bit 0 of A.
- R10: Codes 12 to 15 write false.
- R11: When `issue_en_i` is low no entry changes.
- R12: Any word matching neither compare form (e.g. major opcode 00010 with instr[7:4]!=4'b1111, or other major opcodes) writes nothing.
- R13: A compare issued in one cycle updates the entry at the next rising clock edge; from then on `rd_pred_o` for that entry shows the new value, and compares may issue back to back every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| issue_en_i | input | 1 | Instruction issues this cycle and its guard condition is true |
| instr_i | input | 32 | Instruction word |
| opa_i | input | 32 | Operand A value |
| opb_i | input | 32 | Operand B value (register form) |
| rd_sel_i | input | 4 | Condition entry to read |
| rd_pred_o | output | 1 | Value of the selected entry |

## Verification
All sixteen condition codes are applied to operand pairs chosen to split the orderings. These are equal values, a small positive number against a larger one, values that straddle the sign bit, and all-ones against one. Such pairs tell signed from unsigned ordering, strict from non-strict comparisons, and a sum that carries out of bit 31 from one that does not. The immediate form is exercised with negative and positive immediates, where the register operand disagrees with the immediate. This shows that sign extension takes place and that `opb_i` is ignored. Further stimulus covers a target first set true and then overwritten by a reserved code, writes with the guard low, non-compare words, entry 0 as target, and back-to-back writes to one entry.

// File: rtl/pred_cmp_pkg.sv
package pred_cmp_pkg;

  localparam int unsigned INSTR_W  = 32;
  localparam int unsigned COND_W   = 4;
  localparam int unsigned IMM_W    = 13;

  localparam logic [4:0] MAJ_REGREG = 5'b00010;
  localparam logic [1:0] MAJ_IMMCMP = 2'b11;
  localparam logic [3:0] FN_CMPGRP  = 4'b1111;

  typedef enum logic [COND_W-1:0] {
    COND_EQ   = 4'd0,
    COND_NE   = 4'd1,
    COND_LT   = 4'd2,
    COND_GE   = 4'd3,
    COND_LE   = 4'd4,
    COND_GT   = 4'd5,
    COND_LTU  = 4'd6,
    COND_GEU  = 4'd7,
    COND_LEU  = 4'd8,
    COND_GTU  = 4'd9,
    COND_CRY  = 4'd10,
    COND_ODD  = 4'd11,
    COND_RS12 = 4'd12,
    COND_RS13 = 4'd13,
    COND_RS14 = 4'd14,
    COND_RS15 = 4'd15
  } cond_e;

endpackage

// File: rtl/pred_rst_sync.sv
module pred_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/pred_cmp_decode.sv
module pred_cmp_decode
  import pred_cmp_pkg::*;
#(
  parameter int unsigned SEL_W = 4
) (
  input  logic [INSTR_W-1:0] instr_i,
  output logic               valid_o,
  output logic               use_imm_o,
  output cond_e              cond_o,
  output logic [SEL_W-1:0]   tgt_o,
  output logic [IMM_W-1:0]   imm_o
);
  logic is_rr;
  logic is_ri;
  logic unused_bits;

  always_comb begin
    is_rr     = (instr_i[27:23] == MAJ_REGREG) && (instr_i[7:4] == FN_CMPGRP);
    is_ri     = (instr_i[27:26] == MAJ_IMMCMP);
    valid_o   = is_rr || is_ri;
    use_imm_o = is_ri;
    cond_o    = is_ri ? cond_e'(instr_i[25:22]) : cond_e'(instr_i[3:0]);
    tgt_o     = instr_i[18 +: SEL_W];
    imm_o     = instr_i[IMM_W-1:0];
  end

  // guard field, source-register fields and bit 22 are consumed elsewhere
  assign unused_bits = ^{instr_i[31:28], instr_i[22], instr_i[17:13]};
endmodule

// File: rtl/pred_cmp_eval.sv
module pred_cmp_eval
  import pred_cmp_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  input  cond_e           cond_i,
  output logic            res_o
);
  logic [XLEN:0] sum_w;
  logic          eq_w;
  logic          lts_w;
  logic          ltu_w;

  always_comb begin
    sum_w = {1'b0, opa_i} + {1'b0, opb_i};
    eq_w  = (opa_i == opb_i);
    lts_w = ($signed(opa_i) < $signed(opb_i));
    ltu_w = (opa_i < opb_i);
    unique case (cond_i)
      COND_EQ:  res_o = eq_w;
      COND_NE:  res_o = !eq_w;
      COND_LT:  res_o = lts_w;
      COND_GE:  res_o = !lts_w;
      COND_LE:  res_o = lts_w || eq_w;
      COND_GT:  res_o = !(lts_w || eq_w);
      COND_LTU: res_o = ltu_w;
      COND_GEU: res_o = !ltu_w;
      COND_LEU: res_o = ltu_w || eq_w;
      COND_GTU: res_o = !(ltu_w || eq_w);
      COND_CRY: res_o = sum_w[XLEN];
      COND_ODD: res_o = opa_i[0];
      default:  res_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pred_file.sv
module pred_file #(
  parameter int unsigned NPRED = 16,
  localparam int unsigned SEL_W = $clog2(NPRED)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] waddr_i,
  input  logic             wdata_i,
  input  logic [SEL_W-1:0] raddr_i,
  output logic             rdata_o
);
  logic [NPRED-1:0] entry_w;

  assign entry_w[0] = 1'b1;

  for (genvar i = 1; i < NPRED; i++) begin : g_entry
    logic hit_w;
    logic bit_d;
    logic bit_q;

    always_comb begin
      hit_w = we_i && (waddr_i == SEL_W'(i));
      bit_d = hit_w ? wdata_i : bit_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bit_q <= 1'b0;
      else         bit_q <= bit_d;
    end

    assign entry_w[i] = bit_q;
  end

  assign rdata_o = entry_w[raddr_i];
endmodule

// File: rtl/pred_cmp_unit.sv
module pred_cmp_unit
  import pred_cmp_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned NPRED = 16,
  localparam int unsigned SEL_W = $clog2(NPRED)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               issue_en_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [XLEN-1:0]    opa_i,
  input  logic [XLEN-1:0]    opb_i,
  input  logic [SEL_W-1:0]   rd_sel_i,
  output logic               rd_pred_o
);
  logic             rst_n_sync;
  logic             dec_valid;
  logic             dec_use_imm;
  cond_e            dec_cond;
  logic [SEL_W-1:0] wr_tgt;
  logic [IMM_W-1:0] dec_imm;
  logic [XLEN-1:0]  opb_eff;
  logic             cmp_result;
  logic             wr_en;

  pred_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  pred_cmp_decode #(.SEL_W(SEL_W)) u_dec (
    .instr_i   (instr_i),
    .valid_o   (dec_valid),
    .use_imm_o (dec_use_imm),
    .cond_o    (dec_cond),
    .tgt_o     (wr_tgt),
    .imm_o     (dec_imm)
  );

  always_comb begin
    opb_eff = dec_use_imm ? {{(XLEN-IMM_W){dec_imm[IMM_W-1]}}, dec_imm} : opb_i;
    wr_en   = issue_en_i && dec_valid;
  end

  pred_cmp_eval #(.XLEN(XLEN)) u_eval (
    .opa_i  (opa_i),
    .opb_i  (opb_eff),
    .cond_i (dec_cond),
    .res_o  (cmp_result)
  );

  pred_file #(.NPRED(NPRED)) u_file (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_sync),
    .we_i    (wr_en),
    .waddr_i (wr_tgt),
    .wdata_i (cmp_result),
    .raddr_i (rd_sel_i),
    .rdata_o (rd_pred_o)
  );
endmodule

// File: rtl/pred_cmp_chk.sv
module pred_cmp_chk
  import pred_cmp_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned SEL_W = 4
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             issue_en_i,
  input logic             dec_valid,
  input cond_e            dec_cond,
  input logic [SEL_W-1:0] wr_tgt,
  input logic             cmp_result,
  input logic [XLEN-1:0]  opa_i,
  input logic [SEL_W-1:0] rd_sel_i,
  input logic             rd_pred_o
);
  // R2
  entry0_true_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_sel_i == '0) |-> rd_pred_o);

  // R11
  gated_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !issue_en_i |=> (!$stable(rd_sel_i) || $stable(rd_pred_o)));

  // R12
  noncmp_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !dec_valid |=> (!$stable(rd_sel_i) || $stable(rd_pred_o)));

  // R13
  write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (issue_en_i && dec_valid && wr_tgt == rd_sel_i && wr_tgt != '0)
      |=> (!$stable(rd_sel_i) || rd_pred_o == $past(cmp_result)));

  // R10
  reserved_false_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (dec_valid && dec_cond >= COND_RS12) |-> !cmp_result);

  // R9
  odd_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (dec_valid && dec_cond == COND_ODD) |-> (cmp_result == opa_i[0]));
endmodule

bind pred_cmp_unit pred_cmp_chk #(.XLEN(XLEN), .SEL_W(SEL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_n_sync),
  .issue_en_i (issue_en_i),
  .dec_valid  (dec_valid),
  .dec_cond   (dec_cond),
  .wr_tgt     (wr_tgt),
  .cmp_result (cmp_result),
  .opa_i      (opa_i),
  .rd_sel_i   (rd_sel_i),
  .rd_pred_o  (rd_pred_o)
);

// File: tb/tb_pred_cmp_unit.sv
module tb_pred_cmp_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        issue_en_i;
  logic [31:0] instr_i;
  logic [31:0] opa_i;
  logic [31:0] opb_i;
  logic [3:0]  rd_sel_i;
  logic        rd_pred_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit model [16];

  typedef struct {
    logic [3:0] sel;
    logic       exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #5 clk_i = ~clk_i;

  pred_cmp_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .issue_en_i(issue_en_i), .instr_i(instr_i),
    .opa_i(opa_i), .opb_i(opb_i), .rd_sel_i(rd_sel_i), .rd_pred_o(rd_pred_o)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_rr(input int cond, input int tgt, input bit b22);
    return {4'h0, 5'b00010, b22, 4'(tgt), 5'd3, 5'd4, 4'hF, 4'(cond)};
  endfunction

  function automatic logic [31:0] mk_ri(input int cond, input int tgt, input logic [12:0] imm);
    return {4'h0, 2'b11, 4'(cond), 4'(tgt), 5'd3, imm};
  endfunction

  function automatic logic ref_cond(input int cond, input logic [31:0] a, input logic [31:0] b);
    logic [32:0] s;
    s = 33'(a) + 33'(b);
    case (cond)
      0:  return a == b;
      1:  return a != b;
      2:  return $signed(a) <  $signed(b);
      3:  return $signed(a) >= $signed(b);
      4:  return $signed(a) <= $signed(b);
      5:  return $signed(a) >  $signed(b);
      6:  return a <  b;
      7:  return a >= b;
      8:  return a <= b;
      9:  return a >  b;
      10: return s[32];
      11: return a[0];
      default: return 1'b0;
    endcase
  endfunction

  // driver: apply one instruction, update the reference file, queue the observation
  task automatic drive(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                       input bit en, input int obs, input string tag);
    bit rr, ri;
    logic [31:0] bop;
    int cond, tgt;
    @(negedge clk_i);
    issue_en_i = en; instr_i = ins; opa_i = a; opb_i = b; rd_sel_i = 4'(obs);
    rr   = (ins[27:23] == 5'b00010) && (ins[7:4] == 4'hF);
    ri   = (ins[27:26] == 2'b11);
    cond = ri ? int'(ins[25:22]) : int'(ins[3:0]);
    tgt  = int'(ins[21:18]);
    bop  = ri ? {{19{ins[12]}}, ins[12:0]} : b;
    if (en && (rr || ri) && tgt != 0) model[tgt] = ref_cond(cond, a, bop);
    sb_q.push_back('{sel: 4'(obs), exp: model[obs], tag: tag});
  endtask

  // monitor: after each edge, compare the read port with the queued expectation
  always @(posedge clk_i) begin
    #2;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(rd_pred_o, it.exp, $sformatf("%s sel=%0d", it.tag, it.sel));
    end
  end

  initial begin
    #(200000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  logic [31:0] pa [8] = '{32'd5, 32'd3, 32'd7, 32'hFFFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'd1, 32'd6};
  logic [31:0] pb [8] = '{32'd5, 32'd7, 32'd3, 32'd1, 32'h7FFF_FFFF, 32'd1, 32'hFFFF_FFFF, 32'd2};

  initial begin
    for (int i = 0; i < 16; i++) model[i] = (i == 0);
    rst_ni = 1'b0; issue_en_i = 1'b0; instr_i = '0; opa_i = '0; opb_i = '0; rd_sel_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // R1 R2 reset state
    for (int s = 0; s < 16; s++) begin
      @(negedge clk_i); rd_sel_i = 4'(s); #1;
      check(rd_pred_o, (s == 0), "R1 reset state");
    end

    // R2 entry 0 not writable
    drive(mk_rr(1, 0, 0), 32'd4, 32'd4, 1, 0, "R2 entry0 write");

    // R3 R5 R6 R7 R8 R9 R10 register form, every code, many pairs
    for (int p = 0; p < 8; p++)
      for (int c = 0; c < 16; c++) begin
        int t;
        t = 1 + ((p * 16 + c) % 15);
        drive(mk_rr(c, t, 0), pa[p], pb[p], 1, t,
              (c < 2) ? "R5 eq" : (c < 6) ? "R6 signed" : (c < 10) ? "R7 unsigned" :
              (c == 10) ? "R8 carry" : (c == 11) ? "R9 odd" : "R10 reserved");
      end

    // R10 reserved code clears an entry that was true
    drive(mk_rr(0, 5, 0), 32'd9, 32'd9, 1, 5, "R10 preset");
    drive(mk_rr(13, 5, 0), 32'd9, 32'd9, 1, 5, "R10 reserved clears");

    // R3 bit 22 ignored
    drive(mk_rr(0, 3, 1), 32'd1, 32'd1, 1, 3, "R3 bit22 set");

    // R4 immediate form, sign extension, opb ignored
    drive(mk_ri(6, 4, 13'h1FFF), 32'd5, 32'd0, 1, 4, "R4 ltu neg imm");
    drive(mk_ri(2, 6, 13'h1FFF), 32'd5, 32'd100, 1, 6, "R4 lt neg imm");
    drive(mk_ri(10, 8, 13'h1FFF), 32'd1, 32'd0, 1, 8, "R8 carry imm");
    drive(mk_ri(0, 9, 13'd100), 32'd100, 32'd7, 1, 9, "R4 eq pos imm");
    drive(mk_ri(0, 9, 13'h1000), 32'hFFFF_F000, 32'd0, 1, 9, "R4 eq min imm");
    drive(mk_ri(9, 10, 13'd100), 32'd101, 32'd500, 1, 10, "R4 gtu imm");

    // R11 gated compare
    drive(mk_rr(0, 7, 0), 32'd2, 32'd2, 1, 7, "R11 preset");
    drive(mk_rr(1, 7, 0), 32'd2, 32'd2, 0, 7, "R11 gated");

    // R12 non-compare words
    drive(mk_rr(0, 7, 0) & ~32'h0000_00F0, 32'd1, 32'd2, 1, 7, "R12 rr func");
    drive({4'h0, 5'b00100, 4'd7, 19'h0}, 32'd1, 32'd2, 1, 7, "R12 other op");
    drive({4'h0, 5'b10111, 4'd7, 19'h0}, 32'd1, 32'd2, 1, 7, "R12 jump op");

    // R13 back to back writes to one entry
    drive(mk_rr(0, 2, 0), 32'd1, 32'd1, 1, 2, "R13 b2b set");
    drive(mk_rr(1, 2, 0), 32'd1, 32'd1, 1, 2, "R13 b2b clear");
    drive(mk_rr(11, 2, 0), 32'd3, 32'd0, 1, 2, "R13 b2b set");

    @(negedge clk_i); issue_en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule